// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between a CPU bus and the memories of a game cartridge. Writes into the read-only code space do not reach any memory. They are decoded into control registers: a RAM enable, a 7-bit switchable ROM bank, a selector that picks either an external RAM bank or one of five real-time clock registers, and a latch trigger for the clock.

Reads in the lower half of the space produce ROM addresses. The first 16 KiB always come from bank 0 and the second 16 KiB from the selected bank. The window from 0xA000 to 0xBFFF is shared between external RAM and the latched clock registers, and the current selector mode decides which one an access reaches. The block drives a registered address and a one-cycle enable toward the chosen target. It then returns the target's read data to the CPU in the cycle that follows the read strobe. Gated and unmapped reads return 0xFF.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, external RAM is disabled, RAM mode (not clock mode) is active, and every output enable is low.
- R2: A write with cpu_addr[15:13] = 000 enables external RAM when cpu_wdata[3:0] = 0xA and disables it for any other low nibble. The upper nibble is ignored.
- R3: A write with cpu_addr[15:13] = 001 loads the ROM bank from cpu_wdata[6:0]. A full byte of 0x00 loads bank 1 instead. The zero test uses all eight bits, so 0x80 loads bank 0.
- R4: A write with cpu_addr[15:13] = 010 and data 0 to 3 selects that RAM bank and enters RAM mode.
- R5: A write with cpu_addr[15:13] = 010 and data 0x08 to 0x0C enters clock mode and sets clk_sel to data minus 8. Any other data value leaves the mode, the RAM bank and clk_sel unchanged.
- R6: A write with cpu_addr[15:13] = 011 of 0x01 pulses clk_latch for one cycle when the previous write there was 0x00. Every such write stores its byte as the new previous value, and the stored value resets to 0x01.
- R7: In the cycle after a read strobe, a read below 0x4000 sets rom_rd_en with rom_addr = {0, cpu_addr[13:0]}. A read in 0x4000 to 0x7FFF sets rom_addr = {ROM bank, cpu_addr[13:0]}.
- R8: With RAM enabled and RAM mode active, an access in 0xA000 to 0xBFFF sets ram_rd_en or ram_wr_en in the next cycle. It also sets ram_addr = {RAM bank, cpu_addr[12:0]} and places the write byte on ext_wdata.
- R9: While RAM is disabled, accesses in 0xA000 to 0xBFFF raise no RAM or clock enable, and reads there return 0xFF.
- R10: With RAM enabled and clock mode active, a window write raises clk_wr_en with the byte on ext_wdata. A window read raises clk_rd_en and returns clk_rdata, the latched copy of the register chosen by clk_sel.
- R11: Accesses with cpu_addr[15:13] equal to 100, 110 or 111 raise no enable, and reads there return 0xFF.
- R12: cpu_rdata is valid in the cycle after the read strobe and carries the data of the target that the read was routed to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | 21 | Banked ROM byte address |
| rom_rd_en | output | 1 | ROM read enable |
| rom_rdata | input | 8 | ROM read data |
| ram_addr | output | 15 | Banked external RAM byte address |
| ram_rd_en | output | 1 | External RAM read enable |
| ram_wr_en | output | 1 | External RAM write enable |
| ram_rdata | input | 8 | External RAM read data |
| ext_wdata | output | 8 | Write byte for RAM or clock block |
| clk_sel | output | 3 | Selected clock register |
| clk_rd_en | output | 1 | Clock register read enable |
| clk_wr_en | output | 1 | Clock register write enable (live and latched copy) |
| clk_latch | output | 1 | One-cycle pulse to copy live clock into latched copy |
| clk_rdata | input | 8 | Latched clock register data |

## Verification
On every cycle, the assertions check the reset values of the control registers and how a nonzero bank write loads the ROM bank. They also check that a latch pulse never repeats in back-to-back cycles, that no window enable appears unless RAM was enabled, that low-half ROM reads stay in bank 0, and that unmapped regions raise no enables. Several behaviours depend on the sequence of accesses and can only be shown by the bench's scenarios. These are the zero check on the full byte (0x80 giving bank 0), selector values that are ignored, the 0-then-1 latch sequence with its reset value of 1, and the data path through the shared window. The bench shows the data path by writing a clock register, then changing the live copy, and seeing the read move to the new value only after a latch.

// File: rtl/cart_pkg.sv
package cart_pkg;
  typedef enum logic [1:0] {RT_OPEN, RT_ROM, RT_RAM, RT_CLK} route_t;
  localparam logic [2:0] RG_ENABLE  = 3'b000;
  localparam logic [2:0] RG_ROMBANK = 3'b001;
  localparam logic [2:0] RG_SELECT  = 3'b010;
  localparam logic [2:0] RG_LATCH   = 3'b011;
  localparam logic [2:0] RG_XWIN    = 3'b101;
endpackage

// File: rtl/cart_ctrl_regs.sv
module cart_ctrl_regs #(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  parameter int CLK_REGS   = 5,
  parameter int SEL_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [15:0]           addr,
  input  logic [7:0]            wdata,
  output logic                  ram_en,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  clk_mode,
  output logic [SEL_W-1:0]      clk_sel,
  output logic                  latch_pulse
);
  import cart_pkg::*;
  localparam logic [7:0] RAM_MAX = 8'((1 << RAM_BANK_W) - 1);
  localparam logic [7:0] CLK_LO  = 8'd8;
  localparam logic [7:0] CLK_HI  = 8'(8 + CLK_REGS - 1);

  logic [7:0] prev_latch;
  logic [7:0] sel_ofs;
  logic       hit_en, hit_bank, hit_sel, hit_latch;

  assign hit_en    = wr && (addr[15:13] == RG_ENABLE);
  assign hit_bank  = wr && (addr[15:13] == RG_ROMBANK);
  assign hit_sel   = wr && (addr[15:13] == RG_SELECT);
  assign hit_latch = wr && (addr[15:13] == RG_LATCH);
  assign sel_ofs   = wdata - CLK_LO;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_en      <= 1'b0;
      rom_bank    <= ROM_BANK_W'(1);
      ram_bank    <= '0;
      clk_mode    <= 1'b0;
      clk_sel     <= '0;
      prev_latch  <= 8'h01;
      latch_pulse <= 1'b0;
    end else begin
      latch_pulse <= 1'b0;
      if (hit_en)
        ram_en <= (wdata[3:0] == 4'hA);
      if (hit_bank)
        rom_bank <= (wdata == 8'h00) ? ROM_BANK_W'(1) : wdata[ROM_BANK_W-1:0];
      if (hit_sel) begin
        if (wdata <= RAM_MAX) begin
          clk_mode <= 1'b0;
          ram_bank <= wdata[RAM_BANK_W-1:0];
        end else if (wdata >= CLK_LO && wdata <= CLK_HI) begin
          clk_mode <= 1'b1;
          clk_sel  <= sel_ofs[SEL_W-1:0];
        end
      end
      if (hit_latch) begin
        latch_pulse <= (prev_latch == 8'h00) && (wdata == 8'h01);
        prev_latch  <= wdata;
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rom_bank == ROM_BANK_W'(1) && ram_bank == '0 && !ram_en && !clk_mode));

  // R3
  rom_bank_load_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_bank && wdata != 8'h00) |=> (rom_bank == $past(wdata[ROM_BANK_W-1:0])));

  // R6
  latch_single_chk: assert property (@(posedge clk) disable iff (rst)
    latch_pulse |=> !latch_pulse);
endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map #(
  parameter int ROM_BANK_W = 7,
  parameter int ROM_OFS_W  = 14,
  parameter int RAM_BANK_W = 2,
  parameter int RAM_OFS_W  = 13,
  parameter int ROM_AW     = ROM_BANK_W + ROM_OFS_W,
  parameter int RAM_AW     = RAM_BANK_W + RAM_OFS_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd,
  input  logic                  wr,
  input  logic [15:0]           addr,
  input  logic [7:0]            wdata,
  input  logic                  ram_en,
  input  logic [ROM_BANK_W-1:0] rom_bank,
  input  logic [RAM_BANK_W-1:0] ram_bank,
  input  logic                  clk_mode,
  output logic [ROM_AW-1:0]     rom_addr,
  output logic                  rom_rd_en,
  output logic [RAM_AW-1:0]     ram_addr,
  output logic                  ram_rd_en,
  output logic                  ram_wr_en,
  output logic [7:0]            ext_wdata,
  output logic                  clk_rd_en,
  output logic                  clk_wr_en,
  output cart_pkg::route_t      route
);
  import cart_pkg::*;
  logic in_rom, in_win, win_open;

  assign in_rom   = (addr[15] == 1'b0);
  assign in_win   = (addr[15:13] == RG_XWIN);
  assign win_open = in_win && ram_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr  <= '0;
      rom_rd_en <= 1'b0;
      ram_addr  <= '0;
      ram_rd_en <= 1'b0;
      ram_wr_en <= 1'b0;
      ext_wdata <= '0;
      clk_rd_en <= 1'b0;
      clk_wr_en <= 1'b0;
      route     <= RT_OPEN;
    end else begin
      rom_rd_en <= rd && in_rom;
      ram_rd_en <= rd && win_open && !clk_mode;
      ram_wr_en <= wr && win_open && !clk_mode;
      clk_rd_en <= rd && win_open && clk_mode;
      clk_wr_en <= wr && win_open && clk_mode;
      if (rd && in_rom)
        rom_addr <= {(addr[14] ? rom_bank : ROM_BANK_W'(0)), addr[ROM_OFS_W-1:0]};
      if ((rd || wr) && win_open && !clk_mode)
        ram_addr <= {ram_bank, addr[RAM_OFS_W-1:0]};
      if (wr)
        ext_wdata <= wdata;
      if (rd) begin
        if (in_rom)        route <= RT_ROM;
        else if (!win_open) route <= RT_OPEN;
        else if (clk_mode) route <= RT_CLK;
        else               route <= RT_RAM;
      end
    end
  end

  // R9
  xwin_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_rd_en || ram_wr_en || clk_rd_en || clk_wr_en) |-> $past(ram_en));

  // R7
  rom_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && in_rom && !addr[14]) |=> (rom_rd_en && rom_addr[ROM_AW-1:ROM_OFS_W] == '0));

  // R11
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd || wr) && addr[15] && !in_win) |=>
      !(rom_rd_en || ram_rd_en || ram_wr_en || clk_rd_en || clk_wr_en));
endmodule

// File: rtl/cart_rd_mux.sv
module cart_rd_mux (
  input  cart_pkg::route_t route,
  input  logic [7:0]       rom_rdata,
  input  logic [7:0]       ram_rdata,
  input  logic [7:0]       clk_rdata,
  output logic [7:0]       cpu_rdata
);
  import cart_pkg::*;
  always_comb begin
    case (route)
      RT_ROM:  cpu_rdata = rom_rdata;
      RT_RAM:  cpu_rdata = ram_rdata;
      RT_CLK:  cpu_rdata = clk_rdata;
      default: cpu_rdata = 8'hFF;
    endcase
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
  parameter int ROM_BANK_W = 7,
  parameter int ROM_OFS_W  = 14,
  parameter int RAM_BANK_W = 2,
  parameter int RAM_OFS_W  = 13,
  parameter int CLK_REGS   = 5,
  localparam int SEL_W     = $clog2(CLK_REGS),
  localparam int ROM_AW    = ROM_BANK_W + ROM_OFS_W,
  localparam int RAM_AW    = RAM_BANK_W + RAM_OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [7:0]        cpu_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_rd_en,
  input  logic [7:0]        rom_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_rd_en,
  output logic              ram_wr_en,
  input  logic [7:0]        ram_rdata,
  output logic [7:0]        ext_wdata,
  output logic [SEL_W-1:0]  clk_sel,
  output logic              clk_rd_en,
  output logic              clk_wr_en,
  output logic              clk_latch,
  input  logic [7:0]        clk_rdata
);
  logic                  ram_en, clk_mode;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  cart_pkg::route_t      route;

  cart_ctrl_regs #(
    .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W),
    .CLK_REGS(CLK_REGS), .SEL_W(SEL_W)
  ) regs_i (
    .clk(clk), .rst(rst), .wr(cpu_wr), .addr(cpu_addr), .wdata(cpu_wdata),
    .ram_en(ram_en), .rom_bank(rom_bank), .ram_bank(ram_bank),
    .clk_mode(clk_mode), .clk_sel(clk_sel), .latch_pulse(clk_latch)
  );

  cart_addr_map #(
    .ROM_BANK_W(ROM_BANK_W), .ROM_OFS_W(ROM_OFS_W),
    .RAM_BANK_W(RAM_BANK_W), .RAM_OFS_W(RAM_OFS_W)
  ) map_i (
    .clk(clk), .rst(rst), .rd(cpu_rd), .wr(cpu_wr), .addr(cpu_addr),
    .wdata(cpu_wdata), .ram_en(ram_en), .rom_bank(rom_bank),
    .ram_bank(ram_bank), .clk_mode(clk_mode), .rom_addr(rom_addr),
    .rom_rd_en(rom_rd_en), .ram_addr(ram_addr), .ram_rd_en(ram_rd_en),
    .ram_wr_en(ram_wr_en), .ext_wdata(ext_wdata), .clk_rd_en(clk_rd_en),
    .clk_wr_en(clk_wr_en), .route(route)
  );

  cart_rd_mux mux_i (
    .route(route), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
    .clk_rdata(clk_rdata), .cpu_rdata(cpu_rdata)
  );
endmodule

// File: tb/cart_bank_ctrl_tb_top.sv
module cart_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata, rom_rdata, ram_rdata, clk_rdata, ext_wdata;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic [2:0]  clk_sel;
  logic        rom_rd_en, ram_rd_en, ram_wr_en, clk_rd_en, clk_wr_en, clk_latch;
  logic        bump = 1'b0;
  int          total = 0, fails = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  cart_bank_ctrl dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .rom_addr(rom_addr), .rom_rd_en(rom_rd_en), .rom_rdata(rom_rdata),
    .ram_addr(ram_addr), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en),
    .ram_rdata(ram_rdata), .ext_wdata(ext_wdata), .clk_sel(clk_sel),
    .clk_rd_en(clk_rd_en), .clk_wr_en(clk_wr_en), .clk_latch(clk_latch),
    .clk_rdata(clk_rdata)
  );

  function automatic logic [7:0] rom_f(input logic [20:0] a);
    return a[7:0] ^ {1'b0, a[20:14]};
  endfunction
  assign rom_rdata = rom_f(rom_addr);

  logic [7:0] ram_m [64];
  assign ram_rdata = ram_m[{ram_addr[14:13], ram_addr[3:0]}];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) ram_m[i] <= 8'h00;
    end else if (ram_wr_en) begin
      ram_m[{ram_addr[14:13], ram_addr[3:0]}] <= ext_wdata;
    end
  end

  logic [7:0] live [5];
  logic [7:0] lat  [5];
  assign clk_rdata = (clk_sel < 3'd5) ? lat[clk_sel] : 8'h00;
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 5; i++) begin live[i] <= 8'h00; lat[i] <= 8'h00; end
    end else begin
      if (clk_wr_en && clk_sel < 3'd5) begin
        live[clk_sel] <= ext_wdata;
        lat[clk_sel]  <= ext_wdata;
      end
      if (bump) live[2] <= 8'h99;
      if (clk_latch) for (int i = 0; i < 5; i++) lat[i] <= live[i];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [15:0] a);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  // {rd, addr, data, expected rom_addr, requirement number}
  localparam logic [49:0] VEC [12] = '{
    {1'b1, 16'h0123, 8'h00, 21'h000123, 4'd7},
    {1'b1, 16'h4010, 8'h00, 21'h004010, 4'd1},
    {1'b0, 16'h2000, 8'h05, 21'h000000, 4'd3},
    {1'b1, 16'h7FFF, 8'h00, 21'h017FFF, 4'd3},
    {1'b0, 16'h3ABC, 8'h00, 21'h000000, 4'd3},
    {1'b1, 16'h4000, 8'h00, 21'h004000, 4'd3},
    {1'b0, 16'h2100, 8'h80, 21'h000000, 4'd3},
    {1'b1, 16'h5001, 8'h00, 21'h001001, 4'd3},
    {1'b0, 16'h2000, 8'hFF, 21'h000000, 4'd3},
    {1'b1, 16'h4002, 8'h00, 21'h1FC002, 4'd3},
    {1'b0, 16'h2000, 8'h85, 21'h000000, 4'd3},
    {1'b1, 16'h3FFF, 8'h00, 21'h003FFF, 4'd7}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1 rom_rd_en", rom_rd_en, 0);
    chk("R1 ram enables", {ram_rd_en, ram_wr_en}, 0);
    chk("R1 clk enables", {clk_rd_en, clk_wr_en, clk_latch}, 0);
    do_rd(16'hA000);
    chk("R1 ram disabled read", cpu_rdata, 8'hFF);

    // R6: stored previous value resets to 1, so a first write of 1 gives no pulse
    do_wr(16'h6000, 8'h01);
    chk("R6 no pulse after reset", clk_latch, 0);

    // R3 / R7 / R12 vector walk
    for (int i = 0; i < 12; i++) begin
      logic [49:0] v;
      v = VEC[i];
      if (v[49]) begin
        do_rd(v[48:33]);
        chk($sformatf("R%0d rom_addr vec%0d", v[3:0], i), {rom_rd_en, rom_addr}, {1'b1, v[24:4]});
        chk($sformatf("R12 rom data vec%0d", i), cpu_rdata, rom_f(v[24:4]));
      end else begin
        do_wr(v[48:33], v[32:25]);
      end
    end

    // R1 RAM mode at reset, bank 0; R2 enable
    do_wr(16'h0000, 8'h0A);
    do_wr(16'hA003, 8'h42);
    chk("R1 ram mode write", {ram_wr_en, clk_wr_en}, 2'b10);
    chk("R1 ram bank 0 addr", ram_addr, 15'h0003);

    // R8 banked RAM
    do_wr(16'h4000, 8'h02);
    chk("R4 no enables on select write", {ram_wr_en, clk_wr_en}, 0);
    do_wr(16'hA005, 8'h77);
    chk("R8 write addr", {ram_wr_en, ram_addr}, {1'b1, 15'h4005});
    chk("R8 write data", ext_wdata, 8'h77);
    do_rd(16'hA005);
    chk("R8 read enable", ram_rd_en, 1);
    chk("R12 ram read data", cpu_rdata, 8'h77);
    do_wr(16'h4000, 8'h03);
    do_rd(16'hBFFF);
    chk("R8 top address", ram_addr, 15'h7FFF);

    // R9 disabled window, R2 nibble decode
    do_wr(16'h1F00, 8'h0B);
    do_wr(16'h4000, 8'h02);
    do_wr(16'hA005, 8'h11);
    chk("R9 write ignored", {ram_wr_en, clk_wr_en}, 0);
    do_rd(16'hA005);
    chk("R9 read FF", cpu_rdata, 8'hFF);
    chk("R9 no read enable", ram_rd_en, 0);
    do_wr(16'h0000, 8'hFA);
    do_rd(16'hA005);
    chk("R2 upper nibble ignored, data kept", cpu_rdata, 8'h77);
    do_wr(16'h0000, 8'h3B);
    do_rd(16'hA005);
    chk("R2 disable", cpu_rdata, 8'hFF);
    do_wr(16'h0000, 8'h3A);
    do_rd(16'hA005);
    chk("R2 enable 0x3A", cpu_rdata, 8'h77);

    // R5 / R10 clock mode
    do_wr(16'h4000, 8'h0A);
    chk("R5 clk_sel 2", clk_sel, 3'd2);
    do_wr(16'hA000, 8'h3C);
    chk("R10 clock write", {clk_wr_en, ram_wr_en}, 2'b10);
    chk("R10 clock wdata", ext_wdata, 8'h3C);
    do_rd(16'hA000);
    chk("R10 clock read", {clk_rd_en, ram_rd_en, cpu_rdata}, {2'b10, 8'h3C});
    do_wr(16'h4000, 8'h05);
    do_wr(16'h4000, 8'h0D);
    chk("R5 ignored values keep sel", clk_sel, 3'd2);
    do_rd(16'hA000);
    chk("R5 ignored values keep mode", {clk_rd_en, cpu_rdata}, {1'b1, 8'h3C});

    // R6 latch sequence through the clock block
    @(negedge clk); bump = 1'b1;
    @(negedge clk); bump = 1'b0;
    do_rd(16'hA000);
    chk("R10 read returns latched copy", cpu_rdata, 8'h3C);
    do_wr(16'h6000, 8'h00);
    chk("R6 no pulse on 0", clk_latch, 0);
    do_wr(16'h6000, 8'h01);
    chk("R6 pulse on 0 then 1", clk_latch, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", clk_latch, 0);
    do_rd(16'hA000);
    chk("R6 latched new value", cpu_rdata, 8'h99);
    do_wr(16'h6000, 8'h01);
    chk("R6 no pulse on 1 then 1", clk_latch, 0);
    do_wr(16'h6000, 8'h00);
    do_wr(16'h6000, 8'h02);
    do_wr(16'h6000, 8'h01);
    chk("R6 previous 2 gives no pulse", clk_latch, 0);

    do_wr(16'h4000, 8'h0C);
    chk("R5 clk_sel 4", clk_sel, 3'd4);
    do_wr(16'h4000, 8'h01);
    do_rd(16'hA005);
    chk("R4 back to RAM mode bank 1", {ram_rd_en, clk_rd_en, ram_addr}, {2'b10, 15'h2005});

    // R11 unmapped regions
    do_rd(16'hC000);
    chk("R11 read FF", cpu_rdata, 8'hFF);
    chk("R11 no enables",
        {rom_rd_en, ram_rd_en, ram_wr_en, clk_rd_en, clk_wr_en}, 0);
    do_wr(16'h8000, 8'h0A);
    chk("R11 write no enables", {ram_wr_en, clk_wr_en}, 0);
    do_rd(16'hE123);
    chk("R11 high region FF", {rom_rd_en, cpu_rdata}, {1'b0, 8'hFF});

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule